// File: doc/BRIEF.md
# Host-Coprocessor Mailbox Bridge with Countdown Timer

This block connects a byte-wide host CPU bus to an embedded coprocessor. Each direction has a one-byte mailbox with its own ready flag. The host sees a small register window through which it can fetch the byte the coprocessor left, post a byte for the coprocessor, read a status byte and drive a reset level. The coprocessor sees a memory-mapped port through which it can fetch the host's byte, post its own byte, read its own status and load a 24-bit countdown timer. The timer drives a busy flag that the host can see.

A 0-to-1 edge on the host's reset level resets the coprocessor side of the bridge. The coprocessor stays held while the level is high. After the level is released, and also after power-up, the bridge becomes ready only once a fixed number of tick strobes has arrived. `tick` is a single-cycle enable. It paces both the ready delay and the timer countdown. All state is synchronous to `clk`.

Host window: the address is ANDed with 0xFF06 and then compared against the base 0x3800. Bits 2:1 of the address select the register: offset 0 is coprocessor data, offset 2 is host data and timer clear, offset 4 is status and control. Coprocessor port: 0x00 is data, 0x04 is status, and 0x20, 0x24 and 0x28 are the low, middle and high timer bytes.

Top module: `mbox_bridge`

## Requirements
- R1: A host access hits the window when (address AND 0xFF06) with bits 2:1 removed equals 0x3800. Bits 2:1 select the register, so address bit 0 and bits 7:3 are ignored. A miss reads 0x00 and has no effect.
- R2: A host read of offset 0 returns the coprocessor-to-host byte and clears its ready flag when that flag is set. When the flag is clear, the read returns 0x00.
- R3: A host write to offset 2 stores the byte and sets the host-to-coprocessor ready flag. A coprocessor read of 0x00 returns that byte and clears the flag. A coprocessor read of 0x04 returns bit 0 = host-to-coprocessor ready and bit 1 = coprocessor-to-host ready.
- R4: The host status byte at offset 4 has bit 7 = bridge ready, bit 3 = host-to-coprocessor ready, bit 2 = busy and bit 0 = coprocessor-to-host ready. All other bits read 0.
- R5: A host write to offset 4 keeps only data bit 0 as the reset level. A 0-to-1 change of that level clears the timer, the timer latch, busy, bridge ready and both mailbox ready flags. Writing 1 while the level is already 1 clears nothing.
- R6: While the reset level is 1, bridge ready stays 0 and `copHold` is 1. Once the level is 0, bridge ready rises after exactly READY_DELAY tick strobes.
- R7: Coprocessor writes to 0x20, 0x24 and 0x28 set the low, middle and high latch bytes. Writing the high byte loads the whole latch into the timer and sets busy to 1 exactly when the loaded value is zero. Coprocessor reads of those addresses return the matching byte of the current timer.
- R8: Each tick strobe with a nonzero timer decrements the timer by one. The step that reaches zero clears busy. A zero timer stays at zero.
- R9: A host read of offset 2 returns 0x00 and clears both the timer and busy.
- R10: When a coprocessor data write and a host read of offset 0 fall in the same cycle, the host gets the old byte and the flag stays set with the new byte. The same rule applies symmetrically to a host write to offset 2 that coincides with a coprocessor read of 0x00.
- R11: A coprocessor write to 0x00 stores the byte and sets the coprocessor-to-host ready flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle enable for the delay and the timer |
| hostAddr | input | 16 | Host address |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data (combinational) |
| copAddr | input | 8 | Coprocessor address |
| copRd | input | 1 | Coprocessor read strobe |
| copWr | input | 1 | Coprocessor write strobe |
| copWdata | input | 8 | Coprocessor write data |
| copRdata | output | 8 | Coprocessor read data (combinational) |
| copHold | output | 1 | Coprocessor held (reset level high or bridge not ready) |

## Verification
The hardest case to reach is a read and a set of the same ready flag in one clock. The host strobe and the coprocessor strobe come from independent sides, so ordinary traffic rarely lines them up. The bench therefore raises both strobes at the same falling edge: first with the flag already set and new data arriving, then in the opposite direction. It then reads again to show that the new byte survived. The timer's end-of-count clear can only be seen through the busy bit, and busy is set only by a zero load. The bench therefore follows the count through the coprocessor's timer readback and steps it across the zero boundary.

// File: rtl/mbox_bridge_pkg.sv
package mbox_bridge_pkg;
  localparam int TIMER_BYTES = 3;
  localparam int TIMER_W     = 8 * TIMER_BYTES;

  typedef struct packed {
    logic                   hostDataRd;
    logic                   hostTimerClr;
    logic                   hostMboxWr;
    logic                   hostCtlWr;
    logic                   copDataWr;
    logic                   copDataRd;
    logic [TIMER_BYTES-1:0] copLatchWr;
  } strobes_t;

  typedef enum logic [1:0] {
    HSEL_NONE,
    HSEL_DATA,
    HSEL_STATUS
  } hostSel_t;

  typedef enum logic [2:0] {
    CSEL_NONE,
    CSEL_DATA,
    CSEL_STATUS,
    CSEL_TIMER
  } copSel_t;
endpackage

// File: rtl/mbox_bridge_ctrl.sv
module mbox_bridge_ctrl
  import mbox_bridge_pkg::*;
#(
  parameter logic [15:0] HOST_BASE  = 16'h3800,
  parameter logic [15:0] HOST_MASK  = 16'hFF06,
  parameter int          COP_AW     = 8,
  parameter logic [COP_AW-1:0] COP_DATA   = 8'h00,
  parameter logic [COP_AW-1:0] COP_STATUS = 8'h04,
  parameter logic [COP_AW-1:0] TIMER_BASE = 8'h20
) (
  input  logic [15:0]       hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [COP_AW-1:0] copAddr,
  input  logic              copRd,
  input  logic              copWr,
  output strobes_t          strobes,
  output hostSel_t          hostSel,
  output copSel_t           copSel,
  output logic [$clog2(TIMER_BYTES)-1:0] timerLane
);
  localparam logic [15:0] SEL_BITS = 16'h0006;
  localparam int LANE_W = $clog2(TIMER_BYTES);

  logic [15:0] hostMasked;
  logic        hostHit;
  logic [1:0]  hostOff;
  logic [TIMER_BYTES-1:0] laneHit;

  assign hostMasked = hostAddr & HOST_MASK;
  assign hostHit    = (hostMasked & ~SEL_BITS) == HOST_BASE;
  assign hostOff    = hostMasked[2:1];

  genvar gi;
  generate
    for (gi = 0; gi < TIMER_BYTES; gi++) begin : g_lane
      assign laneHit[gi] = copAddr == TIMER_BASE + COP_AW'(4 * gi);
      assign strobes.copLatchWr[gi] = copWr && laneHit[gi];
    end
  endgenerate

  assign strobes.hostDataRd   = hostRd && hostHit && hostOff == 2'd0;
  assign strobes.hostTimerClr = hostRd && hostHit && hostOff == 2'd1;
  assign strobes.hostMboxWr   = hostWr && hostHit && hostOff == 2'd1;
  assign strobes.hostCtlWr    = hostWr && hostHit && hostOff == 2'd2;
  assign strobes.copDataWr    = copWr && copAddr == COP_DATA;
  assign strobes.copDataRd    = copRd && copAddr == COP_DATA;

  always_comb begin
    hostSel = HSEL_NONE;
    if (hostHit && hostOff == 2'd0) hostSel = HSEL_DATA;
    else if (hostHit && hostOff == 2'd2) hostSel = HSEL_STATUS;
  end

  always_comb begin
    copSel    = CSEL_NONE;
    timerLane = '0;
    if (copAddr == COP_DATA) copSel = CSEL_DATA;
    else if (copAddr == COP_STATUS) copSel = CSEL_STATUS;
    for (int i = 0; i < TIMER_BYTES; i++) begin
      if (laneHit[i]) begin
        copSel    = CSEL_TIMER;
        timerLane = LANE_W'(i);
      end
    end
  end
endmodule

// File: rtl/mbox_bridge_dp.sv
module mbox_bridge_dp
  import mbox_bridge_pkg::*;
#(
  parameter int READY_DELAY = 65536
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  strobes_t           strobes,
  input  hostSel_t           hostSel,
  input  copSel_t            copSel,
  input  logic [$clog2(TIMER_BYTES)-1:0] timerLane,
  input  logic [7:0]         hostWdata,
  input  logic [7:0]         copWdata,
  output logic [7:0]         hostRdata,
  output logic [7:0]         copRdata,
  output logic               copRstPulse,
  output logic               resetLevel,
  output logic               bridgeReady,
  output logic               c2hReady,
  output logic               h2cReady,
  output logic               busy,
  output logic [TIMER_W-1:0] timerVal
);
  localparam int CNT_W = $clog2(READY_DELAY + 1);
  localparam int HI    = TIMER_BYTES - 1;

  logic [7:0]         c2hData, h2cData;
  logic [TIMER_W-1:0] latchVal, loadVal;
  logic [CNT_W-1:0]   delayCnt;
  logic               loadNow;

  assign copRstPulse = strobes.hostCtlWr && hostWdata[0] && !resetLevel;
  assign loadNow     = strobes.copLatchWr[HI];

  always_comb begin
    loadVal = latchVal;
    loadVal[8*HI +: 8] = copWdata;
  end

  // reset level and ready delay
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resetLevel  <= 1'b0;
      bridgeReady <= 1'b0;
      delayCnt    <= '0;
    end else begin
      if (strobes.hostCtlWr) resetLevel <= hostWdata[0];
      if (copRstPulse || resetLevel) begin
        bridgeReady <= 1'b0;
        delayCnt    <= '0;
      end else if (!bridgeReady && tick) begin
        if (delayCnt == CNT_W'(READY_DELAY - 1)) begin
          bridgeReady <= 1'b1;
          delayCnt    <= '0;
        end else begin
          delayCnt <= delayCnt + 1'b1;
        end
      end
    end
  end

  // mailboxes: a set wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c2hData  <= '0;
      h2cData  <= '0;
      c2hReady <= 1'b0;
      h2cReady <= 1'b0;
    end else if (copRstPulse) begin
      c2hReady <= 1'b0;
      h2cReady <= 1'b0;
    end else begin
      if (strobes.copDataWr) begin
        c2hData  <= copWdata;
        c2hReady <= 1'b1;
      end else if (strobes.hostDataRd) begin
        c2hReady <= 1'b0;
      end
      if (strobes.hostMboxWr) begin
        h2cData  <= hostWdata;
        h2cReady <= 1'b1;
      end else if (strobes.copDataRd) begin
        h2cReady <= 1'b0;
      end
    end
  end

  // timer latch, one lane per byte
  genvar gl;
  generate
    for (gl = 0; gl < TIMER_BYTES; gl++) begin : g_latch
      always_ff @(posedge clk) begin
        if (!rst_n || copRstPulse) latchVal[8*gl +: 8] <= '0;
        else if (strobes.copLatchWr[gl]) latchVal[8*gl +: 8] <= copWdata;
      end
    end
  endgenerate

  // countdown timer and busy
  always_ff @(posedge clk) begin
    if (!rst_n || copRstPulse || strobes.hostTimerClr) begin
      timerVal <= '0;
      busy     <= 1'b0;
    end else if (loadNow) begin
      timerVal <= loadVal;
      busy     <= loadVal == '0;
    end else if (tick && timerVal != '0) begin
      timerVal <= timerVal - 1'b1;
      if (timerVal == TIMER_W'(1)) busy <= 1'b0;
    end
  end

  always_comb begin
    unique case (hostSel)
      HSEL_DATA:   hostRdata = c2hReady ? c2hData : 8'h00;
      HSEL_STATUS: hostRdata = {bridgeReady, 3'b000, h2cReady, busy, 1'b0, c2hReady};
      default:     hostRdata = 8'h00;
    endcase
  end

  always_comb begin
    unique case (copSel)
      CSEL_DATA:   copRdata = h2cData;
      CSEL_STATUS: copRdata = {6'b0, c2hReady, h2cReady};
      CSEL_TIMER:  copRdata = timerVal[8*timerLane +: 8];
      default:     copRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
  import mbox_bridge_pkg::*;
#(
  parameter int READY_DELAY = 65536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [15:0] hostAddr,
  input  logic       hostRd,
  input  logic       hostWr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic [7:0] copAddr,
  input  logic       copRd,
  input  logic       copWr,
  input  logic [7:0] copWdata,
  output logic [7:0] copRdata,
  output logic       copHold
);
  strobes_t strobes;
  hostSel_t hostSel;
  copSel_t  copSel;
  logic [$clog2(TIMER_BYTES)-1:0] timerLane;
  logic copRstPulse, resetLevel, bridgeReady, c2hReady, h2cReady, busy;
  logic [TIMER_W-1:0] timerVal;

  mbox_bridge_ctrl #(.COP_AW(8)) u_ctrl (
    .hostAddr (hostAddr),
    .hostRd   (hostRd),
    .hostWr   (hostWr),
    .copAddr  (copAddr),
    .copRd    (copRd),
    .copWr    (copWr),
    .strobes  (strobes),
    .hostSel  (hostSel),
    .copSel   (copSel),
    .timerLane(timerLane)
  );

  mbox_bridge_dp #(.READY_DELAY(READY_DELAY)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .strobes    (strobes),
    .hostSel    (hostSel),
    .copSel     (copSel),
    .timerLane  (timerLane),
    .hostWdata  (hostWdata),
    .copWdata   (copWdata),
    .hostRdata  (hostRdata),
    .copRdata   (copRdata),
    .copRstPulse(copRstPulse),
    .resetLevel (resetLevel),
    .bridgeReady(bridgeReady),
    .c2hReady   (c2hReady),
    .h2cReady   (h2cReady),
    .busy       (busy),
    .timerVal   (timerVal)
  );

  assign copHold = resetLevel || !bridgeReady;
endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk
  import mbox_bridge_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               copRstPulse,
  input logic               resetLevel,
  input logic               bridgeReady,
  input logic               c2hReady,
  input logic               h2cReady,
  input logic               busy,
  input logic [TIMER_W-1:0] timerVal,
  input logic               copDataWr,
  input logic               copDataRd,
  input logic               hostDataRd,
  input logic               hostMboxWr,
  input logic               hostTimerClr,
  input logic               timerLoad,
  input logic               copHold
);
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    copRstPulse |=> !bridgeReady && !c2hReady && !h2cReady && !busy && timerVal == '0); // R5
  AST_HELD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    resetLevel |-> !bridgeReady && copHold); // R6
  AST_C2H_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    copDataWr && !copRstPulse |=> c2hReady); // R10
  AST_H2C_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hostMboxWr && !copRstPulse |=> h2cReady); // R10
  AST_HOST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hostDataRd && !copDataWr |=> !c2hReady); // R2
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && timerVal != '0 && !copRstPulse && !hostTimerClr && !timerLoad
      |=> timerVal == $past(timerVal) - 1'b1); // R8
  AST_TIMER_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && timerVal == TIMER_W'(1) && !copRstPulse && !hostTimerClr && !timerLoad
      |=> !busy); // R8
  AST_HOST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    hostTimerClr |=> !busy && timerVal == '0); // R9
  AST_H2C_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    copDataRd && !hostMboxWr |=> !h2cReady); // R3
endmodule

bind mbox_bridge mbox_bridge_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .copRstPulse (copRstPulse),
  .resetLevel  (resetLevel),
  .bridgeReady (bridgeReady),
  .c2hReady    (c2hReady),
  .h2cReady    (h2cReady),
  .busy        (busy),
  .timerVal    (timerVal),
  .copDataWr   (strobes.copDataWr),
  .copDataRd   (strobes.copDataRd),
  .hostDataRd  (strobes.hostDataRd),
  .hostMboxWr  (strobes.hostMboxWr),
  .hostTimerClr(strobes.hostTimerClr),
  .timerLoad   (strobes.copLatchWr[mbox_bridge_pkg::TIMER_BYTES-1]),
  .copHold     (copHold)
);

// File: tb/mbox_bridge_tb.sv
module mbox_bridge_tb;
  localparam int DLY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [15:0] hostAddr = '0;
  logic hostRd = 1'b0, hostWr = 1'b0;
  logic [7:0] hostWdata = '0, hostRdata;
  logic [7:0] copAddr = '0, copWdata = '0, copRdata;
  logic copRd = 1'b0, copWr = 1'b0;
  logic copHold;

  int checks = 0;
  int misses = 0;
  logic [7:0] d;

  always #10 clk = ~clk;

  mbox_bridge #(.READY_DELAY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .copAddr(copAddr), .copRd(copRd), .copWr(copWr),
    .copWdata(copWdata), .copRdata(copRdata), .copHold(copHold)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk); hostAddr = a; hostWdata = v; hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); hostAddr = a; hostRd = 1'b1; #1 v = hostRdata;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic copWrite(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); copAddr = a; copWdata = v; copWr = 1'b1;
    @(negedge clk); copWr = 1'b0;
  endtask

  task automatic copRead(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); copAddr = a; copRd = 1'b1; #1 v = copRdata;
    @(negedge clk); copRd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_powerup();
    hostRead(16'h3804, d); check("R4 reset status", d, 8'h00);
    check("R6 hold after reset", copHold, 1);
    ticks(DLY - 1);
    hostRead(16'h3804, d); check("R6 not ready one tick early", d, 8'h00);
    ticks(1);
    hostRead(16'h3804, d); check("R6 ready after delay", d, 8'h80);
    check("R6 hold released", copHold, 0);
  endtask

  task automatic t_mailboxes();
    hostRead(16'h3800, d); check("R2 empty read", d, 8'h00);
    copWrite(8'h00, 8'hA5);
    hostRead(16'h3804, d); check("R11 c2h ready in status", d, 8'h81);
    copRead(8'h04, d); check("R3 cop status c2h pending", d, 8'h02);
    hostRead(16'h3800, d); check("R2 data read", d, 8'hA5);
    hostRead(16'h3800, d); check("R2 flag cleared", d, 8'h00);
    hostWrite(16'h3802, 8'h3C);
    hostRead(16'h3804, d); check("R4 h2c bit", d, 8'h88);
    copRead(8'h04, d); check("R3 cop status h2c", d, 8'h01);
    copRead(8'h00, d); check("R3 cop data", d, 8'h3C);
    copRead(8'h04, d); check("R3 h2c cleared", d, 8'h00);
  endtask

  task automatic t_mirror();
    copWrite(8'h00, 8'h11);
    hostRead(16'h38F5, d); check("R1 mirrored status", d, 8'h81);
    hostRead(16'h3904, d); check("R1 miss reads zero", d, 8'h00);
    hostRead(16'h3A00, d); check("R1 miss read no side effect", d, 8'h00);
    hostRead(16'h38F9, d); check("R1 mirrored data", d, 8'h11);
    hostWrite(16'h3902, 8'h77);
    copRead(8'h04, d); check("R1 miss write ignored", d, 8'h00);
  endtask

  task automatic t_collide();
    copWrite(8'h00, 8'h21);
    @(negedge clk);
    copAddr = 8'h00; copWdata = 8'h42; copWr = 1'b1;
    hostAddr = 16'h3800; hostRd = 1'b1;
    #1 d = hostRdata;
    @(negedge clk); copWr = 1'b0; hostRd = 1'b0;
    check("R10 host gets old byte", d, 8'h21);
    hostRead(16'h3800, d); check("R10 new byte kept", d, 8'h42);
    hostWrite(16'h3802, 8'h31);
    @(negedge clk);
    hostAddr = 16'h3802; hostWdata = 8'h62; hostWr = 1'b1;
    copAddr = 8'h00; copRd = 1'b1;
    #1 d = copRdata;
    @(negedge clk); hostWr = 1'b0; copRd = 1'b0;
    check("R10 cop gets old byte", d, 8'h31);
    copRead(8'h04, d); check("R10 h2c flag kept", d, 8'h01);
    copRead(8'h00, d); check("R10 h2c new byte", d, 8'h62);
  endtask

  task automatic t_timer();
    copWrite(8'h20, 8'h05); copWrite(8'h24, 8'h00); copWrite(8'h28, 8'h00);
    copRead(8'h20, d); check("R7 loaded low byte", d, 8'h05);
    hostRead(16'h3804, d); check("R7 nonzero load not busy", d, 8'h80);
    ticks(3);
    copRead(8'h20, d); check("R8 after three ticks", d, 8'h02);
    ticks(2);
    copRead(8'h20, d); check("R8 reached zero", d, 8'h00);
    ticks(2);
    copRead(8'h20, d); check("R8 zero holds", d, 8'h00);
    copWrite(8'h20, 8'h03); copWrite(8'h24, 8'h02); copWrite(8'h28, 8'h01);
    copRead(8'h24, d); check("R7 middle byte", d, 8'h02);
    copRead(8'h28, d); check("R7 high byte", d, 8'h01);
    hostRead(16'h3802, d); check("R9 read returns zero", d, 8'h00);
    copRead(8'h20, d); check("R9 timer cleared", d, 8'h00);
    copWrite(8'h20, 8'h00); copWrite(8'h24, 8'h00); copWrite(8'h28, 8'h00);
    hostRead(16'h3804, d); check("R7 zero load sets busy", d, 8'h84);
    ticks(2);
    hostRead(16'h3804, d); check("R8 busy with zero timer stays", d, 8'h84);
    hostRead(16'h3802, d);
    hostRead(16'h3804, d); check("R9 busy cleared", d, 8'h80);
  endtask

  task automatic t_reset();
    copWrite(8'h00, 8'h99);
    hostWrite(16'h3802, 8'h44);
    copWrite(8'h20, 8'h55); copWrite(8'h24, 8'h00); copWrite(8'h28, 8'h00);
    copWrite(8'h28, 8'h00);
    copWrite(8'h20, 8'h55);
    copWrite(8'h28, 8'h00);
    copWrite(8'h20, 8'h00); copWrite(8'h24, 8'h00); copWrite(8'h28, 8'h00);
    copWrite(8'h20, 8'h55);
    hostRead(16'h3804, d); check("R4 all bits", d, 8'h8D);
    hostWrite(16'h3804, 8'hFF);
    hostRead(16'h3804, d); check("R5 rising edge clears", d, 8'h00);
    check("R6 held while level high", copHold, 1);
    copWrite(8'h00, 8'h12);
    hostWrite(16'h3804, 8'h01);
    hostRead(16'h3804, d); check("R5 no second edge", d, 8'h01);
    ticks(DLY + 3);
    hostRead(16'h3804, d); check("R6 held level blocks ready", d, 8'h01);
    hostRead(16'h3800, d);
    hostWrite(16'h3804, 8'hFE);
    ticks(DLY - 1);
    check("R6 not ready early", copHold, 1);
    ticks(1);
    check("R6 ready after release", copHold, 0);
    copWrite(8'h28, 8'h07);
    copRead(8'h20, d); check("R5 latch low cleared", d, 8'h00);
    copRead(8'h28, d); check("R7 high lane after reset", d, 8'h07);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_powerup();
    t_mailboxes();
    t_mirror();
    t_collide();
    t_timer();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    misses++;
    $display("FAIL watchdog: got %0h expected %0h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
    $finish;
  end
endmodule